// File: doc/BRIEF.md
# Timer with Compare-Capture Unit

This block is a 16-bit up-counter with four compare/capture channels. It is programmed through a small byte-wide register port. The counter can count clock cycles through a selectable divide-by-12 or divide-by-24 prescaler, count falling edges on an external count input, or count prescaled cycles only while an external gate input is high. When the counter overflows, it either reloads from a 16-bit reload register or wraps to zero. In the second case a falling edge on a dedicated reload input performs the load instead.

Each channel owns a 16-bit register and works in one of four modes. It can be off (the register is plain storage). It can compare, where the channel raises its output bit when the counter reaches the register value and drops it at the next overflow, which gives a PWM waveform. It can capture on a rising edge of its capture input. It can capture when software writes the register's low byte. Matches and captures set sticky per-channel flags, and overflow sets a sticky overflow flag. All external inputs pass through a two-flop synchroniser before any edge is detected.

Top module: `tcc_timer`

## Requirements
- R1: After reset every register reads 0, and cmp_out, chan_flag and ovf_flag are 0.
- R2: Register CTRL at address 0 holds the run field in bits [1:0] (0 stop, 1 timer, 2 event, 3 gated), the prescale select in bit 2 (0 divides by 12, 1 divides by 24) and the reload source in bit 3. In timer mode, k clock edges after the run write takes effect, the counter has advanced floor(k/divider) times. With run 0 the counter holds its value.
- R3: In gated mode the counter advances like timer mode while gate_in is high, and it does not advance while gate_in is low.
- R4: In event mode the counter advances by exactly one for each 1-to-0 transition of cnt_in, one cycle after the synchronised edge is detected. Clock cycles alone do not advance it.
- R5: With CTRL bit 3 at 0, an advance from 0xFFFF loads the reload register (address 3 low byte, address 4 high byte) into the counter.
- R6: With CTRL bit 3 at 1, an advance from 0xFFFF gives 0x0000, and a falling edge on reload_in loads the reload register into the counter. With bit 3 at 0, reload_in has no effect.
- R7: Each overflow sets ovf_flag, which is FLAGS (address 6) bit 4. The flag stays set until a FLAGS write with bit 4 at 1 clears it. A FLAGS write with bit 4 at 0 leaves it set.
- R8: Register CHMODE (address 5) gives channel k its mode in bits [2k+1:2k] (0 off, 1 compare, 2 capture on edge, 3 capture on write). In compare mode cmp_out[k] goes to 1 one cycle after the counter equals the channel register and returns to 0 at the next overflow; overflow wins when both happen together. cmp_out[k] is 0 in every other mode. Each 0-to-1 change sets chan_flag[k], which is FLAGS bit k, and a FLAGS write with a 1 in bit k clears it.
- R9: In capture-on-edge mode a rising edge of cap_in[k] copies the counter into channel register k and sets chan_flag[k]. A falling edge changes nothing.
- R10: In capture-on-write mode a write to the low byte of channel k copies the counter into the register instead of the written data and sets chan_flag[k]. Writes to the high byte are ignored in both capture modes.
- R11: Channel k's register sits at address 8+2k (low byte) and 9+2k (high byte). reg_rdata shows the register at reg_addr one cycle later. CTRL, the reload register, CHMODE and the channel registers in off or compare mode read back what was written. The counter reads at addresses 1 (low) and 2 (high), and a write there loads that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| cnt_in | input | 1 | External count input (falling edges counted) |
| gate_in | input | 1 | Gate for gated timer mode, active high |
| reload_in | input | 1 | External reload trigger (falling edge) |
| cap_in | input | 4 | Per-channel capture inputs (rising edge) |
| cmp_out | output | 4 | Per-channel compare outputs |
| chan_flag | output | 4 | Sticky per-channel match/capture flags |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
Counting is exercised at exact cycle counts under both prescaler settings, under a closed and an open gate, and with an edge train on the count input. This separates an off-by-one in the prescaler from a wrong divider or a leaky gate. Random trials place the start value, the reload value and the compare value close to the top of the range, with either reload source. A bench model predicts the final count, the compare output and both flags, which separates reload from wrap and shows whether overflow wins over a compare match. Directed cases drive each capture mode with both input polarities and write the high byte in capture mode, to show which stimulus leaves the channel register alone.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned OVF_BIT = 4;
  localparam int unsigned CC_BASE = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 4'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHMODE = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd6;

  typedef enum logic [1:0] {
    RUN_OFF   = 2'd0,
    RUN_TIMER = 2'd1,
    RUN_EVENT = 2'd2,
    RUN_GATED = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    CH_OFF      = 2'd0,
    CH_CMP      = 2'd1,
    CH_CAP_EDGE = 2'd2,
    CH_CAP_WR   = 2'd3
  } ch_mode_e;

  typedef enum int {
    SYNC_LEVEL = 0,
    SYNC_RISE  = 1,
    SYNC_FALL  = 2
  } sync_kind_e;

  typedef struct packed {
    logic      rld_ext;
    logic      pre_slow;
    run_mode_e run;
  } ctrl_t;
endpackage

// File: rtl/tcc_sync_edge.sv
module tcc_sync_edge
  import tcc_pkg::*;
#(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter sync_kind_e KIND   = SYNC_LEVEL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  if (KIND == SYNC_LEVEL) begin : g_level
    assign o = stg[STAGES-1];
  end else begin : g_edge
    logic [W-1:0] prev_q;
    logic [W-1:0] edge_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= '0;
        edge_q <= '0;
      end else begin
        prev_q <= stg[STAGES-1];
        if (KIND == SYNC_RISE) edge_q <= stg[STAGES-1] & ~prev_q;
        else                   edge_q <= ~stg[STAGES-1] & prev_q;
      end
    end
    assign o = edge_q;

    // R4
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_q != '0) |=> ((edge_q & $past(edge_q)) == '0));
  end
endmodule

// File: rtl/tcc_prescale.sv
module tcc_prescale #(
  parameter int FAST_DIV = 12,
  parameter int SLOW_DIV = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW      = $clog2(MAX_DIV);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = slow ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ch_mode_e     mode,
  input  logic [W-1:0] cnt,
  input  logic         ovf_evt,
  input  logic         cap_rise,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [7:0]   wdata,
  output logic [W-1:0] cc,
  output logic         cmp,
  output logic         hit
);
  logic [W-1:0] cc_q;
  logic         cmp_q;
  logic         cmp_set;
  logic         cap_evt;
  logic         storing;

  assign storing = (mode == CH_OFF) || (mode == CH_CMP);
  assign cap_evt = ((mode == CH_CAP_EDGE) && cap_rise) ||
                   ((mode == CH_CAP_WR) && wr_lo);
  assign cmp_set = (mode == CH_CMP) && !ovf_evt && (cnt == cc_q) && !cmp_q;
  assign hit     = cmp_set || cap_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
    end else if (cap_evt) begin
      cc_q <= cnt;
    end else if (storing) begin
      if (wr_lo) cc_q[7:0]   <= wdata;
      if (wr_hi) cc_q[W-1:8] <= wdata[W-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode != CH_CMP) cmp_q <= 1'b0;
    else if (ovf_evt)          cmp_q <= 1'b0;
    else if (cnt == cc_q)      cmp_q <= 1'b1;
  end

  assign cc  = cc_q;
  assign cmp = cmp_q;

  // R8
  cmp_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_q) |-> $past(cnt == cc_q));

  // R8
  cmp_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmp_q) && $past(mode == CH_CMP)) |-> $past(ovf_evt));

  // R9
  cap_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_CAP_EDGE && cap_rise) |=> (cc_q == $past(cnt)));
endmodule

// File: rtl/tcc_timer.sv
module tcc_timer
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NCH         = 4,
  parameter int FAST_DIV    = 12,
  parameter int SLOW_DIV    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cnt_in,
  input  logic              gate_in,
  input  logic              reload_in,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    cmp_out,
  output logic [NCH-1:0]    chan_flag,
  output logic              ovf_flag
);
  localparam int HI_W = CNT_W - 8;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d, rld_q;
  logic [2*NCH-1:0]   chm_q;
  logic [NCH-1:0]     flag_q, hit, flag_clr;
  logic               ovf_q, ovf_evt;
  logic [7:0]         rdata_q, rd_d;
  logic [CNT_W-1:0]   cc_all [NCH];

  logic cnt_fall, gate_lvl, rld_fall;
  logic [NCH-1:0] cap_rise;
  logic pre_run, pre_tick, tick;
  logic wr_cnt_lo, wr_cnt_hi, wr_flags;

  assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_flags  = reg_wr && (reg_addr == A_FLAGS);

  tcc_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .KIND(SYNC_FALL)) u_sync_cnt (
    .clk(clk), .rst(rst), .d(cnt_in), .o(cnt_fall));
  tcc_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .KIND(SYNC_LEVEL)) u_sync_gate (
    .clk(clk), .rst(rst), .d(gate_in), .o(gate_lvl));
  tcc_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .KIND(SYNC_FALL)) u_sync_rld (
    .clk(clk), .rst(rst), .d(reload_in), .o(rld_fall));
  tcc_sync_edge #(.W(NCH), .STAGES(SYNC_STAGES), .KIND(SYNC_RISE)) u_sync_cap (
    .clk(clk), .rst(rst), .d(cap_in), .o(cap_rise));

  assign pre_run = (ctrl_q.run == RUN_TIMER) ||
                   ((ctrl_q.run == RUN_GATED) && gate_lvl);

  tcc_prescale #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(pre_run), .slow(ctrl_q.pre_slow), .tick(pre_tick));

  assign tick = pre_tick || ((ctrl_q.run == RUN_EVENT) && cnt_fall);

  always_comb begin
    cnt_d   = cnt_q;
    ovf_evt = 1'b0;
    if (ctrl_q.rld_ext && rld_fall) begin
      cnt_d = rld_q;
    end else if (tick) begin
      if (cnt_q == '1) begin
        ovf_evt = 1'b1;
        cnt_d   = ctrl_q.rld_ext ? '0 : rld_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (wr_cnt_lo) cnt_d[7:0]       = reg_wdata;
    if (wr_cnt_hi) cnt_d[CNT_W-1:8] = reg_wdata[HI_W-1:0];
  end

  assign flag_clr = wr_flags ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      chm_q  <= '0;
      flag_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= (flag_q & ~flag_clr) | hit;
      ovf_q  <= (ovf_q & ~(wr_flags && reg_wdata[OVF_BIT])) | ovf_evt;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:   ctrl_q <= ctrl_t'(reg_wdata[3:0]);
          A_RLD_LO: rld_q[7:0] <= reg_wdata;
          A_RLD_HI: rld_q[CNT_W-1:8] <= reg_wdata[HI_W-1:0];
          A_CHMODE: chm_q <= reg_wdata[2*NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tcc_channel #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .mode    (ch_mode_e'(chm_q[2*k +: 2])),
      .cnt     (cnt_q),
      .ovf_evt (ovf_evt),
      .cap_rise(cap_rise[k]),
      .wr_lo   (reg_wr && (reg_addr == ADDR_W'(CC_BASE + 2*k))),
      .wr_hi   (reg_wr && (reg_addr == ADDR_W'(CC_BASE + 2*k + 1))),
      .wdata   (reg_wdata),
      .cc      (cc_all[k]),
      .cmp     (cmp_out[k]),
      .hit     (hit[k])
    );
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_CTRL:   rd_d = 8'(ctrl_q);
      A_CNT_LO: rd_d = cnt_q[7:0];
      A_CNT_HI: rd_d = 8'(cnt_q[CNT_W-1:8]);
      A_RLD_LO: rd_d = rld_q[7:0];
      A_RLD_HI: rd_d = 8'(rld_q[CNT_W-1:8]);
      A_CHMODE: rd_d = 8'(chm_q);
      A_FLAGS: begin
        rd_d[NCH-1:0] = flag_q;
        rd_d[OVF_BIT] = ovf_q;
      end
      default: ;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == ADDR_W'(CC_BASE + 2*k))     rd_d = cc_all[k][7:0];
      if (reg_addr == ADDR_W'(CC_BASE + 2*k + 1)) rd_d = 8'(cc_all[k][CNT_W-1:8]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;
  assign chan_flag = flag_q;
  assign ovf_flag  = ovf_q;

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(wr_flags && reg_wdata[OVF_BIT]));

  // R5
  reload_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !ctrl_q.rld_ext && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == $past(rld_q)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run == RUN_OFF && !reg_wr && !(ctrl_q.rld_ext && rld_fall)) |=> $stable(cnt_q));
endmodule

// File: tb/tcc_timer_tb_top.sv
module tcc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_in = 1'b0, gate_in = 1'b0, reload_in = 1'b0;
  logic [3:0] cap_in = '0;
  logic [3:0] cmp_out, chan_flag;
  logic       ovf_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] CTRL = 4'd0, CNT = 4'd1, RLD = 4'd3, CHM = 4'd5, FLG = 4'd6;

  always #10 clk = ~clk;

  tcc_timer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
    .gate_in(gate_in), .reload_in(reload_in), .cap_in(cap_in),
    .cmp_out(cmp_out), .chan_flag(chan_flag), .ovf_flag(ovf_flag));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a, v[7:0]);
    wr(4'(a + 1), v[15:8]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(4'(a + 1), hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_for(input logic [7:0] ctrl, input int n);
    wr(CTRL, ctrl);
    idle(n);
    wr(CTRL, ctrl & 8'hFC);
    idle(2);
  endtask

  function automatic void model(input logic [15:0] s, input logic [15:0] r,
                                input logic [15:0] cc, input int steps, input bit ext,
                                output logic [15:0] c, output bit cmp,
                                output bit flag, output bit ovf);
    c = s; cmp = (s == cc); flag = cmp; ovf = 1'b0;
    for (int i = 0; i < steps; i++) begin
      if (c == 16'hFFFF) begin
        c = ext ? 16'h0000 : r;
        ovf = 1'b1;
        cmp = (c == cc);
      end else begin
        c = c + 16'd1;
        if (c == cc) cmp = 1'b1;
      end
      flag |= cmp;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    void'($urandom(32'h5EED_0017));
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(CTRL, b);  chk("R1 ctrl", b, 0);
    rd16(CNT, v); chk("R1 counter", v, 0);
    rd(FLG, b);   chk("R1 flags", b, 0);
    chk("R1 outputs", {cmp_out, chan_flag, ovf_flag}, 0);

    // R11 readback
    wr(CTRL, 8'h0C); rd(CTRL, b); chk("R11 ctrl readback", b, 8'h0C);
    wr16(RLD, 16'hC3A5); rd16(RLD, v); chk("R11 reload readback", v, 16'hC3A5);
    wr(CHM, 8'hE4); rd(CHM, b); chk("R11 chmode readback", b, 8'hE4);
    wr(CHM, 8'h00); wr16(4'd14, 16'hA55A); rd16(4'd14, v); chk("R11 cc3 readback", v, 16'hA55A);
    wr(CTRL, 8'h00);

    // R2 timer, divide by 12 and by 24
    wr16(CNT, 16'h0100); run_for(8'h01, 59);
    rd16(CNT, v); chk("R2 timer div12", v, 16'h0105);
    wr16(CNT, 16'h0100); run_for(8'h05, 59);
    rd16(CNT, v); chk("R2 timer div24", v, 16'h0102);
    idle(30); rd16(CNT, v); chk("R2 stopped hold", v, 16'h0102);

    // R3 gated
    gate_in = 1'b0; wr16(CNT, 16'h0200); run_for(8'h03, 200);
    rd16(CNT, v); chk("R3 gate closed", v, 16'h0200);
    gate_in = 1'b1; idle(5); run_for(8'h03, 47);
    rd16(CNT, v); chk("R3 gate open", v, 16'h0204);

    // R4 event counting
    wr16(CNT, 16'h00FE); wr(CTRL, 8'h02); idle(40);
    for (int p = 0; p < 5; p++) begin
      cnt_in = 1'b1; idle(3); cnt_in = 1'b0; idle(3);
    end
    idle(6); wr(CTRL, 8'h00); idle(2);
    rd16(CNT, v); chk("R4 event count", v, 16'h0103);

    // R5 overflow reload, R7 sticky flag
    wr16(RLD, 16'h1234); wr16(CNT, 16'hFFFE); run_for(8'h01, 35);
    rd16(CNT, v); chk("R5 reload on overflow", v, 16'h1235);
    chk("R7 ovf set", ovf_flag, 1);
    wr(FLG, 8'h0F); idle(1); chk("R7 ovf kept by bit4=0 write", ovf_flag, 1);
    wr(FLG, 8'h10); idle(1); chk("R7 ovf cleared", ovf_flag, 0);

    // R6 external reload source
    wr16(RLD, 16'hBEEF); wr(CTRL, 8'h00); wr16(CNT, 16'h0042);
    reload_in = 1'b1; idle(5); reload_in = 1'b0; idle(6);
    rd16(CNT, v); chk("R6 reload_in ignored in source 0", v, 16'h0042);
    wr(CTRL, 8'h08);
    reload_in = 1'b1; idle(5); reload_in = 1'b0; idle(6);
    rd16(CNT, v); chk("R6 reload_in edge loads", v, 16'hBEEF);
    wr16(CNT, 16'hFFFF); run_for(8'h09, 11);
    rd16(CNT, v); chk("R6 wrap to zero", v, 16'h0000);
    wr(CTRL, 8'h00); wr(FLG, 8'h1F);

    // R8 compare directed
    wr16(4'd8, 16'h0010); wr16(CNT, 16'h000C); wr(CHM, 8'h01);
    run_for(8'h01, 95);
    rd16(CNT, v); chk("R8 count", v, 16'h0014);
    chk("R8 cmp_out set", cmp_out[0], 1);
    chk("R8 flag set", chan_flag[0], 1);
    wr(CHM, 8'h00); idle(2); chk("R8 cmp_out off mode", cmp_out[0], 0);
    wr(FLG, 8'h1F);

    // R9 capture on edge
    wr(CHM, 8'h08); wr16(CNT, 16'h3C5A);
    cap_in[1] = 1'b1; idle(6);
    rd16(4'd10, v); chk("R9 capture on rise", v, 16'h3C5A);
    chk("R9 flag", chan_flag[1], 1);
    wr16(CNT, 16'h1111); cap_in[1] = 1'b0; idle(6);
    rd16(4'd10, v); chk("R9 fall ignored", v, 16'h3C5A);

    // R10 capture on write
    wr(CHM, 8'h30); wr16(CNT, 16'h7E01);
    wr(4'd12, 8'h99); idle(1);
    rd16(4'd12, v); chk("R10 capture on low write", v, 16'h7E01);
    chk("R10 flag", chan_flag[2], 1);
    wr(4'd13, 8'h55); idle(1);
    rd16(4'd12, v); chk("R10 high write ignored", v, 16'h7E01);
    wr(CHM, 8'h00);

    // R2 R5 R6 R8 random trials
    gate_in = 1'b1;
    for (int t = 0; t < 40; t++) begin
      logic [15:0] s, r, cc, ec;
      bit ext, slow, gated, ecmp, eflag, eovf;
      int n, steps;
      logic [7:0] ctrl;
      ext = 1'($urandom_range(0, 1));
      slow = 1'($urandom_range(0, 1));
      gated = 1'($urandom_range(0, 1));
      s = 16'hFFFF - 16'($urandom_range(0, 40));
      r = 16'($urandom_range(0, 65535));
      cc = ($urandom_range(0, 3) == 0) ? r + 16'($urandom_range(0, 4))
                                       : s + 16'($urandom_range(0, 60));
      n = $urandom_range(0, 599);
      steps = (n + 1) / (slow ? 24 : 12);
      ctrl = {4'b0, ext, slow, gated ? 2'b11 : 2'b01};
      model(s, r, cc, steps, ext, ec, ecmp, eflag, eovf);
      wr(CTRL, ctrl & 8'hFC); wr(CHM, 8'h00); wr(FLG, 8'h1F);
      wr16(CNT, s); wr16(RLD, r); wr16(4'd8, cc); wr(CHM, 8'h01);
      run_for(ctrl, n);
      rd16(CNT, v); chk("R2 R5 R6 random count", v, ec);
      chk("R8 random cmp_out", cmp_out[0], ecmp);
      rd(FLG, b); chk("R7 R8 random flags", b, {3'b0, eovf, 3'b0, eflag});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule